// File: doc/BRIEF.md
# AES-128 Next-Round-Key Generator

This block computes one step of the AES-128 key schedule. Given the current 128-bit round key and a 5-bit round immediate, it produces the round key that follows. The input is a vector of `NUM_GROUPS` independent 128-bit element groups. Each group is treated as four 32-bit words, with word 0 in the least significant bits. All groups in one operation share the same round number. There is no per-group masking.

The round immediate is never rejected. Its low four bits are taken as the round. A value outside 1..10 is folded back into that range by inverting bit 3. The transform for each group is as follows:

1. Take the top word and rotate it right by one byte.
2. Pass each byte through the forward AES substitution box.
3. XOR the round constant into the lowest byte.
4. Fold the result through the four input words in a chained XOR.

The result is registered once. `out_valid` marks the cycle that carries a fresh result. `key_out` keeps its value until the next accepted request.

Top module: `aesks_step`

## Requirements
- R1: Only bits [3:0] of `round_imm` select the round; bit 4 has no effect on the result.
- R2: If the 4-bit round r is in 1..10 it is used as is; otherwise the effective round is r with bit 3 inverted (0→8, 11→3, 12→4, 13→5, 14→6, 15→7).
- R3: The round constant for effective round e is xtime applied (e−1) times to 0x01, giving 0x01, 0x02, 0x04, 0x08, 0x10, 0x20, 0x40, 0x80, 0x1B, 0x36 for e = 1..10. It is XORed into bits [7:0] of the substituted word.
- R4: The substituted word is word 3 (bits [127:96] of a group) rotated right by 8 bits, then with each byte replaced by the forward AES S-box value. The S-box is the GF(2^8) inverse modulo 0x11B (0 maps to 0) followed by the affine map with constant 0x63.
- R5: With input words k0..k3 and substituted word t, the outputs are n0 = k0^t, n1 = k1^n0, n2 = k2^n1 and n3 = k3^n2.
- R6: Word i of group g occupies bits [128g+32i+31 : 128g+32i] on both `key_in` and `key_out`.
- R7: Every group uses the same round. Each group's result depends only on its own input words.
- R8: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `key_out` changes only after a cycle with `in_valid` high and otherwise holds its value.
- R9: A synchronous active-high `rst` clears `out_valid` and `key_out` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; captures a new result |
| round_imm | input | 5 | Round immediate (low 4 bits used) |
| key_in | input | 128*NUM_GROUPS | Current round keys, one 128-bit group per slot |
| out_valid | output | 1 | High for one cycle with each fresh result |
| key_out | output | 128*NUM_GROUPS | Next round keys, registered |

## Verification
The bench sweeps all 32 round immediates, so every folded round is covered. A design that rejected out-of-range rounds, folded with the wrong bit, or let bit 4 leak in would show a mismatched constant in the low byte.

Every byte value is driven through each of the four substitution lanes and compared against a model that finds field inverses by search. This exposes a wrong table entry, a wrong rotation direction or a swapped byte lane.

A published first-round vector pins down word order and byte order. Changing inputs while the strobe is low shows whether a design updates its output without a request.

// File: rtl/aesks_pkg.sv
package aesks_pkg;

    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 32;
    localparam int GRP_WORDS = 4;
    localparam int GRP_W     = WORD_W * GRP_WORDS;
    localparam int IMM_W     = 5;
    localparam int ROUND_W   = 4;
    localparam int MAX_ROUND = 10;

    typedef logic [BYTE_W-1:0]  byte_t;
    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [ROUND_W-1:0] round_t;

    // Packed so that w0 lands in the least significant 32 bits.
    typedef struct packed {
        word_t w3;
        word_t w2;
        word_t w1;
        word_t w0;
    } key_grp_t;

    typedef struct packed {
        round_t eff;
        byte_t  rcon;
    } round_info_t;

    function automatic byte_t gf_xtime(input byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc = '0;
        byte_t x   = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ x;
            x = gf_xtime(x);
        end
        return acc;
    endfunction

    // Inverse as x^254 = x^2 * x^4 * ... * x^128; zero maps to zero.
    function automatic byte_t gf_inv(input byte_t a);
        byte_t sq  = a;
        byte_t acc = 8'h01;
        for (int i = 1; i < BYTE_W; i++) begin
            sq  = gf_mul(sq, sq);
            acc = gf_mul(acc, sq);
        end
        return (a == 8'h00) ? 8'h00 : acc;
    endfunction

    function automatic byte_t rotl8(input byte_t a, input int n);
        return byte_t'((a << n) | (a >> (BYTE_W - n)));
    endfunction

    function automatic byte_t sbox_fwd(input byte_t a);
        byte_t v = gf_inv(a);
        return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
    endfunction

    function automatic round_t fold_round(input logic [IMM_W-1:0] imm);
        round_t r = imm[ROUND_W-1:0];
        if (r >= round_t'(1) && r <= round_t'(MAX_ROUND)) return r;
        return r ^ round_t'(8);
    endfunction

    function automatic byte_t rcon_of(input round_t eff);
        byte_t c = 8'h01;
        for (int i = 1; i < MAX_ROUND; i++) begin
            if (round_t'(i) < eff) c = gf_xtime(c);
        end
        return c;
    endfunction

endpackage

// File: rtl/aesks_round_ctl.sv
module aesks_round_ctl
    import aesks_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IMM_W-1:0]     round_imm,
    output round_info_t          info
);
    round_t eff;

    always_comb begin
        eff       = fold_round(round_imm);
        info.eff  = eff;
        info.rcon = rcon_of(eff);
    end

    // R2: folded round always lands inside the legal window
    a_r2_eff_in_range: assert property (@(posedge clk) disable iff (rst)
        (info.eff >= round_t'(1)) && (info.eff <= round_t'(MAX_ROUND)));

    // R3: constant is a single bit or one of the two reduced values
    a_r3_rcon_legal: assert property (@(posedge clk) disable iff (rst)
        $onehot(info.rcon) || info.rcon == 8'h1b || info.rcon == 8'h36);

endmodule

// File: rtl/aesks_sub_word.sv
module aesks_sub_word
    import aesks_pkg::*;
(
    input  word_t word_in,
    output word_t word_out
);
    localparam int LANES = WORD_W / BYTE_W;

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        byte_t lane_out;
        always_comb lane_out = sbox_fwd(word_in[b*BYTE_W +: BYTE_W]);
        assign word_out[b*BYTE_W +: BYTE_W] = lane_out;
    end

endmodule

// File: rtl/aesks_group_step.sv
module aesks_group_step
    import aesks_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  key_grp_t cur,
    input  byte_t    rcon,
    output key_grp_t nxt
);
    word_t rot_w;
    word_t sub_w;
    word_t tmp_w;

    always_comb rot_w = {cur.w3[BYTE_W-1:0], cur.w3[WORD_W-1:BYTE_W]};

    aesks_sub_word u_sub (
        .word_in  (rot_w),
        .word_out (sub_w)
    );

    always_comb begin
        tmp_w  = sub_w ^ {{(WORD_W-BYTE_W){1'b0}}, rcon};
        nxt.w0 = cur.w0 ^ tmp_w;
        nxt.w1 = cur.w1 ^ nxt.w0;
        nxt.w2 = cur.w2 ^ nxt.w1;
        nxt.w3 = cur.w3 ^ nxt.w2;
    end

    // R5: top output word equals the XOR of all input words and the temp word
    a_r5_top_word_fold: assert property (@(posedge clk) disable iff (rst)
        nxt.w3 == (cur.w0 ^ cur.w1 ^ cur.w2 ^ cur.w3 ^ tmp_w));

    // R3: the constant touches only the low byte of the temp word
    a_r3_rcon_low_byte: assert property (@(posedge clk) disable iff (rst)
        (tmp_w[WORD_W-1:BYTE_W] == sub_w[WORD_W-1:BYTE_W]));

endmodule

// File: rtl/aesks_step.sv
module aesks_step
    import aesks_pkg::*;
#(
    parameter int NUM_GROUPS = 2,
    localparam int BUS_W = NUM_GROUPS * GRP_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [IMM_W-1:0]   round_imm,
    input  logic [BUS_W-1:0]   key_in,
    output logic               out_valid,
    output logic [BUS_W-1:0]   key_out
);
    round_info_t          rinfo;
    logic [BUS_W-1:0]     next_bus;

    aesks_round_ctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .round_imm (round_imm),
        .info      (rinfo)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        key_grp_t cur_g;
        key_grp_t nxt_g;
        assign cur_g = key_grp_t'(key_in[g*GRP_W +: GRP_W]);

        aesks_group_step u_step (
            .clk  (clk),
            .rst  (rst),
            .cur  (cur_g),
            .rcon (rinfo.rcon),
            .nxt  (nxt_g)
        );

        assign next_bus[g*GRP_W +: GRP_W] = nxt_g;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            key_out   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) key_out <= next_bus;
        end
    end

    // R8: a request yields a strobe one cycle later
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R8: no request, no strobe
    a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R8: output holds without a request
    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(key_out));

endmodule

// File: tb/aesks_step_test.sv
module aesks_step_test;

    localparam int NG  = 2;
    localparam int BW  = NG * 128;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [4:0]      round_imm = '0;
    logic [BW-1:0]   key_in = '0;
    logic            out_valid;
    logic [BW-1:0]   key_out;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;
    logic [31:0] lfsr = 32'h1234_5678;

    aesks_step #(.NUM_GROUPS(NG)) uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .round_imm (round_imm),
        .key_in    (key_in),
        .out_valid (out_valid),
        .key_out   (key_out)
    );

    always #10 clk = ~clk;

    // ---------------- independent model ----------------
    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011b << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] m_sbox(input logic [7:0] x);
        logic [7:0] v = 8'h00;
        logic [7:0] c = 8'h63;
        logic [7:0] s;
        for (int y = 1; y < 256; y++) if (x != 0 && m_mul(x, 8'(y)) == 8'h01) v = 8'(y);
        for (int i = 0; i < 8; i++)
            s[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8] ^ c[i];
        return s;
    endfunction

    function automatic logic [7:0] m_rcon(input int e);
        case (e)
            1: return 8'h01;  2: return 8'h02;  3: return 8'h04;  4: return 8'h08;
            5: return 8'h10;  6: return 8'h20;  7: return 8'h40;  8: return 8'h80;
            9: return 8'h1b; 10: return 8'h36;
            default: return 8'hxx;
        endcase
    endfunction

    function automatic int m_round(input logic [4:0] imm);
        int r = int'(imm[3:0]);
        if (r >= 1 && r <= 10) return r;
        return r ^ 8;
    endfunction

    function automatic logic [127:0] m_step(input logic [127:0] k, input logic [4:0] imm);
        logic [31:0] w [4];
        logic [31:0] t;
        logic [31:0] n [4];
        for (int i = 0; i < 4; i++) w[i] = k[32*i +: 32];
        t = {w[3][7:0], w[3][31:8]};
        for (int b = 0; b < 4; b++) t[8*b +: 8] = m_sbox(t[8*b +: 8]);
        t[7:0] = t[7:0] ^ m_rcon(m_round(imm));
        n[0] = w[0] ^ t;
        for (int i = 1; i < 4; i++) n[i] = w[i] ^ n[i-1];
        return {n[3], n[2], n[1], n[0]};
    endfunction

    function automatic logic [BW-1:0] m_bus(input logic [BW-1:0] k, input logic [4:0] imm);
        logic [BW-1:0] r;
        for (int g = 0; g < NG; g++) r[128*g +: 128] = m_step(k[128*g +: 128], imm);
        return r;
    endfunction

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input logic [BW-1:0] act,
                         input logic [BW-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic rnd_word(output logic [31:0] v);
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        lfsr = lfsr * 32'd1664525 + 32'd1013904223;
        v = lfsr;
    endtask

    // drive one request at a negedge, return result after the capturing edge
    task automatic run(input logic [4:0] imm, input logic [BW-1:0] k,
                       output logic [BW-1:0] res, output logic vld);
        @(negedge clk);
        in_valid  = 1'b1;
        round_imm = imm;
        key_in    = k;
        @(negedge clk);
        in_valid  = 1'b0;
        res = key_out;
        vld = out_valid;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
        finish_run();
    end

    initial begin
        logic [BW-1:0] k, res, res2, held;
        logic          vld;
        logic [31:0]   tw;

        // R9: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && key_out == '0, "R9 reset", key_out, '0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R8 idle after reset", BW'(out_valid), '0);

        // model sanity: known substitution values
        check(m_sbox(8'h00) == 8'h63 && m_sbox(8'h53) == 8'hed, "R4 model sbox",
              BW'({m_sbox(8'h00), m_sbox(8'h53)}), BW'(16'h63ed));

        // R6/R4/R5: published first-round vector in group 0, little-endian words
        k = '0;
        k[127:0] = {32'h3c4fcf09, 32'h8815f7ab, 32'ha6d2ae28, 32'h16157e2b};
        run(5'd1, k, res, vld);
        check(res[127:0] == {32'h05766c2a, 32'h3939a323, 32'hb12c5488, 32'h17fefaa0},
              "R6 known vector", BW'(res[127:0]),
              BW'({32'h05766c2a, 32'h3939a323, 32'hb12c5488, 32'h17fefaa0}));
        check(vld == 1'b1, "R8 valid after request", BW'(vld), BW'(1));

        // R1/R2/R3/R7: every immediate, random keys per group
        for (int imm = 0; imm < 32; imm++) begin
            for (int rep = 0; rep < 3; rep++) begin
                for (int w = 0; w < BW/32; w++) begin
                    rnd_word(tw);
                    k[32*w +: 32] = tw;
                end
                run(5'(imm), k, res, vld);
                check(res == m_bus(k, 5'(imm)), $sformatf("R2 R3 R7 imm=%0d", imm),
                      res, m_bus(k, 5'(imm)));
            end
        end

        // R1: bit 4 ignored; R2: folded pairs agree
        rnd_word(tw); k = {8{tw}};
        rnd_word(tw); k[31:0] = tw;
        for (int imm = 0; imm < 16; imm++) begin
            run(5'(imm), k, res, vld);
            run(5'(imm + 16), k, res2, vld);
            check(res == res2, $sformatf("R1 bit4 imm=%0d", imm), res2, res);
        end
        run(5'd0, k, res, vld);  run(5'd8, k, res2, vld);
        check(res == res2, "R2 fold 0->8", res, res2);
        run(5'd11, k, res, vld); run(5'd3, k, res2, vld);
        check(res == res2, "R2 fold 11->3", res, res2);
        run(5'd15, k, res, vld); run(5'd7, k, res2, vld);
        check(res == res2, "R2 fold 15->7", res, res2);

        // R4: every byte through every lane of word 3, both groups
        for (int base = 0; base < 256; base += 4) begin
            for (int rot = 0; rot < 4; rot++) begin
                k = '0;
                for (int b = 0; b < 4; b++) begin
                    k[96 + 8*b +: 8]  = 8'(base + ((b + rot) % 4));
                    k[224 + 8*b +: 8] = 8'(255 - base - b);
                end
                rnd_word(tw); k[31:0] = tw;
                run(5'd4, k, res, vld);
                check(res == m_bus(k, 5'd4), $sformatf("R4 lanes base=%0d", base),
                      res, m_bus(k, 5'd4));
            end
        end

        // R5: chain with zero key isolates the temp word
        k = '0;
        run(5'd10, k, res, vld);
        check(res == m_bus(k, 5'd10), "R5 zero key chain", res, m_bus(k, 5'd10));

        // R8: output holds and no strobe while inputs move without a request
        rnd_word(tw); k = {8{tw}};
        run(5'd2, k, held, vld);
        @(negedge clk);
        key_in = ~k; round_imm = 5'd9;
        @(negedge clk);
        @(negedge clk);
        check(key_out == held, "R8 hold", key_out, held);
        check(out_valid == 1'b0, "R8 no strobe", BW'(out_valid), '0);

        // R9: reset mid-run clears output
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(key_out == '0 && out_valid == 1'b0, "R9 reset clears", key_out, '0);

        finish_run();
    end

endmodule